// File: doc/BRIEF.md
# In-Order Four-Stage Pipeline with Decode Interlock

This block is a small in-order processing pipeline with four stages: instruction fetch, decode with operand read, execute, and register writeback. Each adjacent pair of stages is separated by a holding register, so up to four instructions are in flight at once. Instructions come from a read-only program image that is fixed by a parameter. Fetch walks through the first `PROG_LEN` words of that image in order and then supplies only empty slots.

There are no bypass paths. The register file changes only when an instruction leaves writeback. Decode therefore compares its source registers against the destinations held in the execute and writeback stages. On a match it stops fetch and decode and sends an empty slot (a bubble) into execute, and it keeps doing so until the producing instruction has written back. A multiply stays in execute for several cycles. While it does, every stage upstream holds its contents and writeback receives nothing.

Each completed write is visible on a writeback port. Two free-running counters, one for retired instructions and one for cycles since reset, let the surrounding logic measure throughput and stall cost.

Top module: `inorder_pipe4`

## Requirements
- R1: While reset is high and in the first cycle after it, `wb_valid` is 0 and both counters read 0. Reset loads register k with the value k for every k from 0 to 7.
- R2: An instruction word is 16 bits wide. Bits [15:14] hold the operation: 00 add (rs1+rs2), 01 subtract (rs1-rs2), 10 multiply (rs1*rs2), 11 move (rs1). Bits [13:11] hold rd, bits [10:8] hold rs1 and bits [7:5] hold rs2. Bits [4:0] are unused. Results are kept modulo 2^DATA_W.
- R3: Starting from reset, the instruction at program index 0 writes back in the cycle where `cycle_count` is 3. Independent single-cycle instructions then write back on consecutive cycles, so four of them complete within 7 cycles.
- R4: An instruction's result is written to the register file only in the cycle it holds writeback. An instruction that reads the register in any earlier cycle receives the old value.
- R5: Decode stalls while rs1, or rs2 for an operation that uses it, equals the rd of a valid instruction in execute or in writeback. The dependent instruction reads the register in the cycle after the write. A dependency on the immediately preceding instruction costs 2 bubbles; a dependency on the instruction two places earlier costs 1.
- R6: A move does not use rs2, so its rs2 field never causes a stall.
- R7: A multiply occupies execute for MUL_LAT cycles (default 3). During that time fetch, decode and the decode/execute buffer hold their contents, and no write-back occurs in the following cycles.
- R8: `cycle_count` increases by one on every clock after reset. `retired_count` increases by one in the cycle after each `wb_valid` cycle and at no other time.
- R9: Exactly PROG_LEN instructions write back, in program order. No write-back occurs after the last one.
- R10: Starting from R2=2, R3=3 and R4=4, the sequence R2=R3+R2, R4=R2+R2, R3=R4 writes back the values 5, 10 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | output | 1 | An instruction is writing back this cycle |
| wb_rd | output | 3 | Destination register being written |
| wb_data | output | DATA_W | Value being written |
| retired_count | output | CNT_W | Number of instructions that have written back |
| cycle_count | output | CNT_W | Cycles elapsed since reset was released |

## Verification
The assertions assume that PROG_LEN does not exceed ROM_DEPTH. They also assume that reset is held for at least one clock before the first program cycle, so that the pipeline registers and the counters start empty. The bench builds its program image so that it stays within those limits and holds reset for three cycles. The program is ordered so that each hazard distance, the back-to-back dependency chain, a multiply stall, and a multiply followed by a consumer all occur after the pipeline has drained or reached a known state. This keeps every write-back cycle predictable from the timing rules alone.

// File: rtl/ilock_pkg.sv
package ilock_pkg;

    localparam int INSTR_W  = 16;
    localparam int RA_W     = 3;
    localparam int NUM_REGS = 1 << RA_W;
    localparam int FIELD_W  = 2 + 3 * RA_W;
    localparam int FIELD_LO = INSTR_W - FIELD_W;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_MOV = 2'b11
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [RA_W-1:0] rd;
        logic [RA_W-1:0] rs1;
        logic [RA_W-1:0] rs2;
    } fields_t;

    typedef struct packed {
        logic    valid;
        fields_t f;
    } fd_slot_t;

    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [RA_W-1:0] rd;
    } de_ctl_t;

    function automatic logic reads_rs2(op_e op);
        return op != OP_MOV;
    endfunction

    function automatic logic [INSTR_W-1:0] enc(op_e op, logic [RA_W-1:0] rd,
                                               logic [RA_W-1:0] rs1,
                                               logic [RA_W-1:0] rs2);
        return {op, rd, rs1, rs2, {FIELD_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/ilock_fetch.sv
module ilock_fetch
    import ilock_pkg::*;
#(
    parameter int ROM_DEPTH = 16,
    parameter int PROG_LEN  = 16,
    parameter logic [ROM_DEPTH*INSTR_W-1:0] ROM_IMAGE = '0,
    localparam int IDX_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
    localparam int PC_W  = $clog2(ROM_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    output logic            f_valid,
    output fields_t         f_fields,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] LEN_P = PC_W'(PROG_LEN);

    fields_t rom [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
        assign rom[g] = fields_t'(ROM_IMAGE[g*INSTR_W + FIELD_LO +: FIELD_W]);
    end

    logic [IDX_W-1:0] idx;
    assign idx      = IDX_W'(pc);
    assign f_valid  = pc < LEN_P;
    assign f_fields = f_valid ? rom[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (!hold && f_valid) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/ilock_regfile.sv
module ilock_regfile
    import ilock_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   ra1,
    input  logic [RA_W-1:0]   ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    input  logic              we,
    input  logic [RA_W-1:0]   wa,
    input  logic [DATA_W-1:0] wd
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= DATA_W'(g);
            end else if (we && wa == RA_W'(g)) begin
                q <= wd;
            end
        end
        assign regs[g] = q;
    end

    // Reads see the stored value only; a same-cycle write is not forwarded.
    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/ilock_hazard.sv
module ilock_hazard
    import ilock_pkg::*;
#(
    parameter int N_WATCH = 2
) (
    input  logic            d_valid,
    input  fields_t         d_fields,
    input  logic            watch_valid [N_WATCH],
    input  logic [RA_W-1:0] watch_rd    [N_WATCH],
    output logic            hazard
);

    logic [N_WATCH-1:0] hit1;
    logic [N_WATCH-1:0] hit2;

    for (genvar g = 0; g < N_WATCH; g++) begin : g_cmp
        assign hit1[g] = watch_valid[g] && (watch_rd[g] == d_fields.rs1);
        assign hit2[g] = watch_valid[g] && (watch_rd[g] == d_fields.rs2);
    end

    assign hazard = d_valid &&
                    ((|hit1) || (reads_rs2(d_fields.op) && (|hit2)));

endmodule

// File: rtl/ilock_execute.sv
module ilock_execute
    import ilock_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MUL_LAT = 3,
    localparam int CNT_W  = (MUL_LAT > 1) ? $clog2(MUL_LAT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic              hold
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MUL_LAT - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] prod;

    assign prod = a * b;
    assign done = in_valid && ((op != OP_MUL) || (cnt == LAST));
    assign hold = in_valid && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_MUL:  result = prod;
            default: result = a;
        endcase
    end

endmodule

// File: rtl/inorder_pipe4.sv
module inorder_pipe4
    import ilock_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MUL_LAT   = 3,
    parameter int ROM_DEPTH = 16,
    parameter int PROG_LEN  = 16,
    parameter int CNT_W     = 32,
    parameter logic [ROM_DEPTH*INSTR_W-1:0] ROM_IMAGE = '0,
    localparam int PC_W     = $clog2(ROM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              wb_valid,
    output logic [RA_W-1:0]   wb_rd,
    output logic [DATA_W-1:0] wb_data,
    output logic [CNT_W-1:0]  retired_count,
    output logic [CNT_W-1:0]  cycle_count
);

    // Fetch stage
    logic            f_valid;
    fields_t         f_fields;
    logic [PC_W-1:0] pc;
    logic            d_stall;

    ilock_fetch #(
        .ROM_DEPTH (ROM_DEPTH),
        .PROG_LEN  (PROG_LEN),
        .ROM_IMAGE (ROM_IMAGE)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .hold     (d_stall),
        .f_valid  (f_valid),
        .f_fields (f_fields),
        .pc       (pc)
    );

    // Fetch/decode buffer
    fd_slot_t fd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_q <= '0;
        end else if (!d_stall) begin
            fd_q <= '{valid: f_valid, f: f_fields};
        end
    end

    // Decode: operand read and interlock
    de_ctl_t           de_q;
    logic [DATA_W-1:0] de_a;
    logic [DATA_W-1:0] de_b;
    logic              ew_valid;
    logic [RA_W-1:0]   ew_rd;
    logic [DATA_W-1:0] ew_data;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic              hazard;
    logic              e_hold;
    logic              e_done;
    logic              de_valid;
    logic [DATA_W-1:0] e_result;

    ilock_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (fd_q.f.rs1),
        .ra2 (fd_q.f.rs2),
        .rd1 (op_a),
        .rd2 (op_b),
        .we  (ew_valid),
        .wa  (ew_rd),
        .wd  (ew_data)
    );

    logic            watch_valid [2];
    logic [RA_W-1:0] watch_rd    [2];

    assign watch_valid[0] = de_q.valid;
    assign watch_rd[0]    = de_q.rd;
    assign watch_valid[1] = ew_valid;
    assign watch_rd[1]    = ew_rd;

    ilock_hazard #(.N_WATCH(2)) u_hazard (
        .d_valid     (fd_q.valid),
        .d_fields    (fd_q.f),
        .watch_valid (watch_valid),
        .watch_rd    (watch_rd),
        .hazard      (hazard)
    );

    assign d_stall  = hazard || e_hold;
    assign de_valid = de_q.valid;

    // Decode/execute buffer: holds while execute is busy, else bubble on hazard
    always_ff @(posedge clk) begin
        if (rst) begin
            de_q <= '0;
            de_a <= '0;
            de_b <= '0;
        end else if (!e_hold) begin
            de_q.valid <= fd_q.valid && !hazard;
            de_q.op    <= fd_q.f.op;
            de_q.rd    <= fd_q.f.rd;
            de_a       <= op_a;
            de_b       <= op_b;
        end
    end

    // Execute
    ilock_execute #(
        .DATA_W  (DATA_W),
        .MUL_LAT (MUL_LAT)
    ) u_exec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (de_q.valid),
        .op       (de_q.op),
        .a        (de_a),
        .b        (de_b),
        .result   (e_result),
        .done     (e_done),
        .hold     (e_hold)
    );

    // Execute/writeback buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            ew_valid <= 1'b0;
            ew_rd    <= '0;
            ew_data  <= '0;
        end else begin
            ew_valid <= e_done;
            ew_rd    <= de_q.rd;
            ew_data  <= e_result;
        end
    end

    // Counters
    always_ff @(posedge clk) begin
        if (rst) begin
            retired_count <= '0;
            cycle_count   <= '0;
        end else begin
            cycle_count <= cycle_count + 1'b1;
            if (ew_valid) begin
                retired_count <= retired_count + 1'b1;
            end
        end
    end

    assign wb_valid = ew_valid;
    assign wb_rd    = ew_rd;
    assign wb_data  = ew_data;

endmodule

// File: rtl/inorder_pipe4_chk.sv
module inorder_pipe4_chk #(
    parameter int PROG_LEN = 16,
    parameter int PC_W     = 5,
    parameter int CNT_W    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_valid,
    input logic [CNT_W-1:0] retired_count,
    input logic [CNT_W-1:0] cycle_count,
    input logic             d_stall,
    input logic             hazard,
    input logic             e_hold,
    input logic             de_valid,
    input logic [PC_W-1:0]  pc
);

    localparam logic [PC_W-1:0]  LEN_PC  = PC_W'(PROG_LEN);
    localparam logic [CNT_W-1:0] LEN_CNT = CNT_W'(PROG_LEN);

    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> retired_count == $past(retired_count) + 1'b1); // R8

    AST_RETIRE_FLAT: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |=> retired_count == $past(retired_count)); // R8

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cycle_count == $past(cycle_count) + 1'b1); // R8

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        d_stall |=> $stable(pc)); // R5

    AST_HAZARD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (hazard && !e_hold) |=> !de_valid); // R5

    AST_BUSY_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        e_hold |=> !wb_valid); // R7

    AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
        pc <= LEN_PC); // R9

    AST_RETIRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        retired_count <= LEN_CNT); // R9

endmodule

bind inorder_pipe4 inorder_pipe4_chk #(
    .PROG_LEN (PROG_LEN),
    .PC_W     (PC_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wb_valid      (wb_valid),
    .retired_count (retired_count),
    .cycle_count   (cycle_count),
    .d_stall       (d_stall),
    .hazard        (hazard),
    .e_hold        (e_hold),
    .de_valid      (de_valid),
    .pc            (pc)
);

// File: tb/inorder_pipe4_test.sv
module inorder_pipe4_test;
    import ilock_pkg::*;

    localparam int DATA_W   = 16;
    localparam int CNT_W    = 32;
    localparam int DEPTH    = 16;
    localparam int PLEN     = 15;
    localparam int MAX_EV   = 32;

    // Program: segments for each scenario, index 0 at the low end.
    localparam logic [DEPTH*INSTR_W-1:0] IMG = {
        16'h0000,
        enc(OP_SUB, 3'd7, 3'd3, 3'd5),   // 14 rs2 depends on #12 (distance 2)
        enc(OP_ADD, 3'd6, 3'd1, 3'd1),   // 13
        enc(OP_ADD, 3'd5, 3'd0, 3'd0),   // 12
        enc(OP_ADD, 3'd4, 3'd2, 3'd1),   // 11 depends on multiply
        enc(OP_MUL, 3'd2, 3'd2, 3'd3),   // 10
        enc(OP_MOV, 3'd1, 3'd7, 3'd0),   // 9  waits behind multiply
        enc(OP_MUL, 3'd6, 3'd6, 3'd6),   // 8
        enc(OP_ADD, 3'd5, 3'd1, 3'd2),   // 7
        enc(OP_MOV, 3'd3, 3'd4, 3'd0),   // 6
        enc(OP_ADD, 3'd4, 3'd2, 3'd2),   // 5
        enc(OP_ADD, 3'd2, 3'd3, 3'd2),   // 4
        enc(OP_MOV, 3'd1, 3'd4, 3'd0),   // 3  rs2=R0 while R0 is in flight
        enc(OP_ADD, 3'd0, 3'd3, 3'd4),   // 2
        enc(OP_SUB, 3'd6, 3'd7, 3'd2),   // 1
        enc(OP_ADD, 3'd5, 3'd1, 3'd1)    // 0
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wb_valid;
    logic [RA_W-1:0]   wb_rd;
    logic [DATA_W-1:0] wb_data;
    logic [CNT_W-1:0]  retired_count;
    logic [CNT_W-1:0]  cycle_count;

    inorder_pipe4 #(
        .DATA_W    (DATA_W),
        .MUL_LAT   (3),
        .ROM_DEPTH (DEPTH),
        .PROG_LEN  (PLEN),
        .CNT_W     (CNT_W),
        .ROM_IMAGE (IMG)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .wb_valid      (wb_valid),
        .wb_rd         (wb_rd),
        .wb_data       (wb_data),
        .retired_count (retired_count),
        .cycle_count   (cycle_count)
    );

    always #2 clk = ~clk;

    int checks    = 0;
    int failures  = 0;
    bit timed_out = 1'b0;

    // Write-back event log, sampled on the falling edge
    int               n_ev = 0;
    logic [CNT_W-1:0] ev_cc  [MAX_EV];
    logic [CNT_W-1:0] ev_ret [MAX_EV];
    logic [RA_W-1:0]  ev_rd  [MAX_EV];
    logic [DATA_W-1:0] ev_dat[MAX_EV];

    always @(negedge clk) begin
        if (!rst && wb_valid && n_ev < MAX_EV) begin
            ev_cc[n_ev]  = cycle_count;
            ev_ret[n_ev] = retired_count;
            ev_rd[n_ev]  = wb_rd;
            ev_dat[n_ev] = wb_data;
            n_ev = n_ev + 1;
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        timed_out = 1'b1;
    end

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_events(input int n);
        while (n_ev < n && !timed_out) @(negedge clk);
    endtask

    task automatic chk_event(input int i, input int cc, input int rd,
                             input int data, input string req);
        if (i >= n_ev) begin
            chk(1'b0, $sformatf("%s missing write-back #%0d", req, i), n_ev, i + 1);
            return;
        end
        chk(ev_cc[i] == CNT_W'(cc), $sformatf("%s wb#%0d cycle", req, i), ev_cc[i], cc);
        chk(ev_rd[i] == RA_W'(rd), $sformatf("%s wb#%0d rd", req, i), 32'(ev_rd[i]), rd);
        chk(ev_dat[i] == DATA_W'(data), $sformatf("%s wb#%0d data", req, i),
            32'(ev_dat[i]), data);
        chk(ev_ret[i] == CNT_W'(i), $sformatf("R8 wb#%0d retired_count", i), ev_ret[i], i);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wb_valid == 1'b0, "R1 wb_valid in reset", 32'(wb_valid), 0);
        chk(cycle_count == '0, "R1 cycle_count in reset", cycle_count, 0);
        chk(retired_count == '0, "R1 retired_count in reset", retired_count, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cycle_count == CNT_W'(1), "R8 cycle_count one clock after reset", cycle_count, 1);
        chk(wb_valid == 1'b0, "R1 no write-back right after reset", 32'(wb_valid), 0);
    endtask

    // R3 four independent instructions, R2 encodings, R6 move ignores rs2, R1 reset values
    task automatic t_independent;
        wait_events(4);
        chk_event(0, 3, 5, 2, "R3 R1 add");
        chk_event(1, 4, 6, 5, "R3 R2 sub");
        chk_event(2, 5, 0, 7, "R3 R2 add");
        chk_event(3, 6, 1, 4, "R6 R3 move");
    endtask

    // R10 dependency chain, R5 two bubbles each, R4 old value not seen
    task automatic t_chain;
        wait_events(7);
        chk_event(4, 7, 2, 5, "R10 first add");
        chk_event(5, 10, 4, 10, "R5 R4 R10 second add");
        chk_event(6, 13, 3, 10, "R5 R10 move");
    endtask

    // R7 multiply holds execute for three cycles
    task automatic t_multiply;
        wait_events(10);
        chk_event(7, 14, 5, 9, "R7 add before multiply");
        chk_event(8, 17, 6, 25, "R7 multiply");
        chk_event(9, 18, 1, 7, "R7 move held behind multiply");
    endtask

    // R7 and R5 consumer of a multiply result
    task automatic t_mul_dep;
        wait_events(12);
        chk_event(10, 21, 2, 50, "R7 multiply with prior results");
        chk_event(11, 24, 4, 57, "R5 consumer of multiply");
    endtask

    // R5 distance-two dependency through rs2 costs one bubble; R2 wraps
    task automatic t_distance2;
        wait_events(15);
        chk_event(12, 25, 5, 14, "R5 producer");
        chk_event(13, 26, 6, 14, "R5 independent");
        chk_event(14, 28, 7, 16'hFFFC, "R5 R2 rs2 distance two wrap");
    endtask

    // R9 nothing after the program end
    task automatic t_drain;
        while (cycle_count < CNT_W'(45) && !timed_out) @(negedge clk);
        chk(n_ev == PLEN, "R9 write-back total", n_ev, PLEN);
        chk(retired_count == CNT_W'(PLEN), "R9 R8 retired_count at end",
            retired_count, PLEN);
        chk(wb_valid == 1'b0, "R9 idle after program", 32'(wb_valid), 0);
    endtask

    initial begin
        t_reset();
        t_independent();
        t_chain();
        t_multiply();
        t_mul_dep();
        t_distance2();
        t_drain();
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_ev, PLEN);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule